// File: doc/BRIEF.md
# Doorbell Command Mailbox Register Block

This block sits on the device side of a host-to-device command channel. The host sees a small register window on a 64-bit register bus with per-byte lane enables, so both 32-bit and 64-bit accesses work. The window holds a read-only capability word, a control word with a doorbell bit, a command word, a status word, a payload area and a read-only device status byte. The host fills in the command word and the payload and then sets the doorbell. The block reports the new command to a local executor with a one-cycle start pulse. It also presents the opcode and the input length to the executor, and gives the executor a word-wide port into the payload area.

When the executor signals completion, the block stores the return code and the output length in a single edge and drops the doorbell in that same edge. While the doorbell is high, the host cannot change the command word or the payload. While it is low, the executor cannot change them. As a result, nothing the host reads back after completion can shift underneath it.

Top module: `mbox_regs`

## Requirements
- R1: Reads return data on `bus_rdata_o`, with `bus_rvalid_o` high, in the cycle after the read request. The qword at offset 0x00 carries the payload size exponent `PL_LOG2` in bits 4:0. This field is read-only and ignores host writes.
- R2: The doorbell is bit 32 of the qword at 0x00, which is bit 0 of the 32-bit word at 0x04. A host write with lane 4 enabled and data bit 32 at 1 sets it. Writing a 0 there has no effect.
- R3: In the cycle after the doorbell is set, `exec_start_o` is high for exactly one cycle. In that cycle `exec_busy_o` is high and `exec_opcode_o`/`exec_len_o` show the command word.
- R4: The command qword at 0x08 holds the opcode in bits 15:0 and the payload length in bits 36:16. It can be written per byte lane. Bits 63:37 read as 0.
- R5: While the doorbell is set, host writes to the command qword and to the payload area are ignored.
- R6: On `exec_done_i` while busy, one edge does three things: it places `exec_rc_i` in bits 47:32 of the status qword at 0x10, places `exec_out_len_i` in bits 36:16 of the command qword while keeping the opcode, and clears the doorbell.
- R7: `exec_done_i` has no effect while the doorbell is clear.
- R8: Once the doorbell has cleared, the status, command and payload contents stay unchanged until the host writes them again.
- R9: The payload area starts at 0x20 and spans 2^`PL_LOG2` bytes, with host writes per byte lane. The executor reads the qword at index `exec_pl_addr_i` combinationally. Executor writes take effect only while busy.
- R10: The byte at offset `MDEV_OFF` (default 0x200) reads as follows: fatal in bit 0, firmware halted in bit 1, media state in bits 3:2 (0 not ready, 1 ready, 2 error, 3 disabled), mailbox interface ready in bit 4, and reset-needed kind in bits 7:5 (0 none, 1 cold, 2 warm, 3 hot, 4 link).
- R11: Reads of unmapped offsets, such as 0x18, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address, qword aligned |
| bus_be_i | input | 8 | Byte lane enables for writes |
| bus_wdata_i | input | 64 | Write data |
| bus_rvalid_o | output | 1 | Read data valid |
| bus_rdata_o | output | 64 | Read data |
| exec_start_o | output | 1 | One-cycle pulse for a new command |
| exec_busy_o | output | 1 | Doorbell state |
| exec_opcode_o | output | 16 | Command opcode |
| exec_len_o | output | 21 | Command length field |
| exec_pl_addr_i | input | PL_LOG2-3 | Executor payload qword index |
| exec_pl_rdata_o | output | 64 | Executor payload read data |
| exec_pl_we_i | input | 1 | Executor payload write |
| exec_pl_wdata_i | input | 64 | Executor payload write data |
| exec_done_i | input | 1 | Command completion |
| exec_rc_i | input | 16 | Return code, 0 = success |
| exec_out_len_i | input | 21 | Output payload length |
| dev_fatal_i | input | 1 | Device fatal error |
| dev_fw_halt_i | input | 1 | Firmware halted |
| dev_media_i | input | 2 | Media state |
| dev_mbox_rdy_i | input | 1 | Mailbox interface ready |
| dev_reset_need_i | input | 3 | Reset-needed kind |

## Verification
The bench rings the doorbell and then tries to overwrite the command word and the payload while the command is in flight. A block that fails to gate these writes would hand the executor a changed opcode, or would return a payload the host never got to submit. The bench raises completion while idle and also issues an executor payload write while idle. A design that does not qualify either input by the doorbell would corrupt a finished result. Completion is checked for the return code, the output length with the opcode kept, and a doorbell drop in the same edge. This catches a length written into the wrong field or a doorbell that clears early. Partial lane writes to the command word show that bits above 36 stay zero and that single lanes land in the right place.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OFF_CAPCTL = 32'h00;
  localparam int unsigned OFF_CMD    = 32'h08;
  localparam int unsigned OFF_STAT   = 32'h10;
  localparam int unsigned OFF_PL     = 32'h20;
  localparam int unsigned OPC_W      = 16;
  localparam int unsigned LEN_W      = 21;
  localparam int unsigned RC_W       = 16;
  localparam int unsigned CMD_W      = OPC_W + LEN_W;
  localparam int unsigned DB_BIT     = 32;

  typedef enum logic [1:0] {
    MEDIA_NOT_RDY = 2'd0, MEDIA_RDY = 2'd1, MEDIA_ERR = 2'd2, MEDIA_OFF = 2'd3
  } media_e;

  typedef enum logic [2:0] {
    RNEED_NONE = 3'd0, RNEED_COLD = 3'd1, RNEED_WARM = 3'd2,
    RNEED_HOT = 3'd3, RNEED_LINK = 3'd4
  } rneed_e;

  // packed MSB first: fatal lands in bit 0
  typedef struct packed {
    rneed_e rneed;
    logic   mbox_rdy;
    media_e media;
    logic   fw_halt;
    logic   fatal;
  } dev_stat_t;

  typedef struct packed {
    logic capctl;
    logic cmd;
    logic stat;
    logic pl;
    logic mdev;
  } sel_t;
endpackage

// File: rtl/mbox_decode.sv
module mbox_decode
  import mbox_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned PL_LOG2  = 8,
  parameter int unsigned MDEV_OFF = 32'h200,
  localparam int unsigned PL_AW   = PL_LOG2 - 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output sel_t              sel_o,
  output logic [PL_AW-1:0]  idx_o
);
  localparam int unsigned PL_BYTES = 1 << PL_LOG2;

  logic [31:0] a32;
  logic [31:0] rel;
  logic [31:0] qw;

  assign a32 = 32'(addr_i);
  assign qw  = a32 >> 3;
  assign rel = (a32 - OFF_PL) >> 3;

  assign sel_o.capctl = (qw == (OFF_CAPCTL >> 3));
  assign sel_o.cmd    = (qw == (OFF_CMD >> 3));
  assign sel_o.stat   = (qw == (OFF_STAT >> 3));
  assign sel_o.pl     = (a32 >= OFF_PL) && (a32 < OFF_PL + PL_BYTES);
  assign sel_o.mdev   = (qw == (MDEV_OFF >> 3));
  assign idx_o        = rel[PL_AW-1:0];

  logic unused_ok;
  assign unused_ok = ^{rel[31:PL_AW]};
endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  sel_t             sel_i,
  input  logic [7:0]       be_i,
  input  logic [63:0]      wdata_i,
  input  logic             done_i,
  input  logic [RC_W-1:0]  rc_i,
  input  logic [LEN_W-1:0] out_len_i,
  output logic             db_o,
  output logic             start_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic [RC_W-1:0]  rc_o
);
  logic             db_q, start_q;
  logic [CMD_W-1:0] cmd_q;
  logic [RC_W-1:0]  rc_q;
  logic             ring, cmd_we, finish;
  logic [39:0]      cmd_mrg;

  assign ring   = wr_i && sel_i.capctl && be_i[4] && wdata_i[DB_BIT];
  assign cmd_we = wr_i && sel_i.cmd && !db_q;
  assign finish = db_q && done_i;

  always_comb begin
    cmd_mrg = {3'b0, cmd_q};
    for (int b = 0; b < 5; b++) begin
      if (be_i[b]) cmd_mrg[8*b +: 8] = wdata_i[8*b +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      db_q    <= 1'b0;
      start_q <= 1'b0;
      cmd_q   <= '0;
      rc_q    <= '0;
    end else begin
      start_q <= ring && !db_q;
      if (!db_q && ring) db_q <= 1'b1;
      else if (finish)   db_q <= 1'b0;
      if (cmd_we) cmd_q <= cmd_mrg[CMD_W-1:0];
      else if (finish) cmd_q[CMD_W-1:OPC_W] <= out_len_i;
      if (finish) rc_q <= rc_i;
    end
  end

  assign db_o    = db_q;
  assign start_o = start_q;
  assign cmd_o   = cmd_q;
  assign rc_o    = rc_q;

  logic unused_ok;
  assign unused_ok = ^{wdata_i[63:40], be_i[7:5], cmd_mrg[39:CMD_W],
                       sel_i.stat, sel_i.pl, sel_i.mdev};
endmodule

// File: rtl/mbox_payload.sv
module mbox_payload #(
  parameter int unsigned PL_AW = 5,
  localparam int unsigned PL_WORDS = 1 << PL_AW
) (
  input  logic             clk_i,
  input  logic             h_we_i,
  input  logic [7:0]       h_be_i,
  input  logic [PL_AW-1:0] h_idx_i,
  input  logic [63:0]      h_wdata_i,
  output logic [63:0]      h_rdata_o,
  input  logic             x_we_i,
  input  logic [PL_AW-1:0] x_idx_i,
  input  logic [63:0]      x_wdata_i,
  output logic [63:0]      x_rdata_o
);
  for (genvar g = 0; g < 8; g++) begin : g_lane
    logic [7:0] mem [PL_WORDS];
    always_ff @(posedge clk_i) begin
      if (h_we_i && h_be_i[g]) mem[h_idx_i] <= h_wdata_i[8*g +: 8];
      else if (x_we_i)         mem[x_idx_i] <= x_wdata_i[8*g +: 8];
    end
    assign h_rdata_o[8*g +: 8] = mem[h_idx_i];
    assign x_rdata_o[8*g +: 8] = mem[x_idx_i];
  end
endmodule

// File: rtl/mbox_regs.sv
module mbox_regs
  import mbox_pkg::*;
#(
  parameter int unsigned PL_LOG2  = 8,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned MDEV_OFF = 32'h200,
  localparam int unsigned PL_AW   = PL_LOG2 - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_be_i,
  input  logic [63:0]       bus_wdata_i,
  output logic              bus_rvalid_o,
  output logic [63:0]       bus_rdata_o,
  output logic              exec_start_o,
  output logic              exec_busy_o,
  output logic [15:0]       exec_opcode_o,
  output logic [20:0]       exec_len_o,
  input  logic [PL_AW-1:0]  exec_pl_addr_i,
  output logic [63:0]       exec_pl_rdata_o,
  input  logic              exec_pl_we_i,
  input  logic [63:0]       exec_pl_wdata_i,
  input  logic              exec_done_i,
  input  logic [15:0]       exec_rc_i,
  input  logic [20:0]       exec_out_len_i,
  input  logic              dev_fatal_i,
  input  logic              dev_fw_halt_i,
  input  logic [1:0]        dev_media_i,
  input  logic              dev_mbox_rdy_i,
  input  logic [2:0]        dev_reset_need_i
);
  sel_t             sel;
  logic [PL_AW-1:0] pl_idx;
  logic             host_wr, host_rd, db;
  logic [CMD_W-1:0] cmd_val;
  logic [RC_W-1:0]  stat_rc;
  logic [63:0]      pl_rdata, rd_mux, rdata_q;
  logic             rvalid_q;
  dev_stat_t        dstat;

  assign host_wr = bus_req_i && bus_we_i;
  assign host_rd = bus_req_i && !bus_we_i;

  mbox_decode #(.ADDR_W(ADDR_W), .PL_LOG2(PL_LOG2), .MDEV_OFF(MDEV_OFF)) u_dec (
    .addr_i(bus_addr_i), .sel_o(sel), .idx_o(pl_idx)
  );

  mbox_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(host_wr), .sel_i(sel),
    .be_i(bus_be_i), .wdata_i(bus_wdata_i), .done_i(exec_done_i),
    .rc_i(exec_rc_i), .out_len_i(exec_out_len_i), .db_o(db),
    .start_o(exec_start_o), .cmd_o(cmd_val), .rc_o(stat_rc)
  );

  mbox_payload #(.PL_AW(PL_AW)) u_pl (
    .clk_i(clk_i),
    .h_we_i(host_wr && sel.pl && !db), .h_be_i(bus_be_i), .h_idx_i(pl_idx),
    .h_wdata_i(bus_wdata_i), .h_rdata_o(pl_rdata),
    .x_we_i(exec_pl_we_i && db), .x_idx_i(exec_pl_addr_i),
    .x_wdata_i(exec_pl_wdata_i), .x_rdata_o(exec_pl_rdata_o)
  );

  assign dstat = '{rneed: rneed_e'(dev_reset_need_i), mbox_rdy: dev_mbox_rdy_i,
                   media: media_e'(dev_media_i), fw_halt: dev_fw_halt_i,
                   fatal: dev_fatal_i};

  always_comb begin
    rd_mux = '0;
    if (sel.capctl)    rd_mux = {31'b0, db, 27'b0, 5'(PL_LOG2)};
    else if (sel.cmd)  rd_mux = {27'b0, cmd_val};
    else if (sel.stat) rd_mux = {16'b0, stat_rc, 32'b0};
    else if (sel.pl)   rd_mux = pl_rdata;
    else if (sel.mdev) rd_mux = {56'b0, dstat};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= host_rd;
      if (host_rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rvalid_o  = rvalid_q;
  assign bus_rdata_o   = rdata_q;
  assign exec_busy_o   = db;
  assign exec_opcode_o = cmd_val[OPC_W-1:0];
  assign exec_len_o    = cmd_val[CMD_W-1:OPC_W];
endmodule

// File: rtl/mbox_regs_chk.sv
module mbox_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        bus_req_i,
  input logic        bus_we_i,
  input logic        bus_rvalid_o,
  input logic        exec_start_o,
  input logic        exec_busy_o,
  input logic        exec_done_i,
  input logic [15:0] exec_opcode_o,
  input logic [20:0] exec_len_o,
  input logic [15:0] rc_i
);
  assert_rvalid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rvalid_o == $past(bus_req_i && !bus_we_i));

  assert_start_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |=> !exec_start_o);

  assert_start_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> exec_busy_o && !$past(exec_busy_o));

  assert_lock_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_busy_o && $past(exec_busy_o) |-> $stable(exec_opcode_o) && $stable(exec_len_o));

  assert_clear_on_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(exec_busy_o) |-> $past(exec_done_i));

  assert_idle_rc_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_busy_o && !$past(exec_busy_o) |-> $stable(rc_i));
endmodule

bind mbox_regs mbox_regs_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
  .bus_rvalid_o(bus_rvalid_o), .exec_start_o(exec_start_o),
  .exec_busy_o(exec_busy_o), .exec_done_i(exec_done_i),
  .exec_opcode_o(exec_opcode_o), .exec_len_o(exec_len_o), .rc_i(stat_rc)
);

// File: tb/sim_mbox_regs.sv
`timescale 1ns/1ps
module sim_mbox_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 0, we = 0;
  logic [9:0]  addr = '0;
  logic [7:0]  be = '0;
  logic [63:0] wdata = '0;
  logic        rvalid;
  logic [63:0] rdata;
  logic        start, busy;
  logic [15:0] opc;
  logic [20:0] len;
  logic [4:0]  x_addr = '0;
  logic [63:0] x_rdata;
  logic        x_we = 0;
  logic [63:0] x_wdata = '0;
  logic        done = 0;
  logic [15:0] rc = '0;
  logic [20:0] olen = '0;
  logic        fatal = 0, halt = 0, mrdy = 0;
  logic [1:0]  media = '0;
  logic [2:0]  rneed = '0;
  int total = 0, bad = 0;
  logic fin = 0;

  always #4 clk = ~clk;

  mbox_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata),
    .bus_rvalid_o(rvalid), .bus_rdata_o(rdata), .exec_start_o(start),
    .exec_busy_o(busy), .exec_opcode_o(opc), .exec_len_o(len),
    .exec_pl_addr_i(x_addr), .exec_pl_rdata_o(x_rdata), .exec_pl_we_i(x_we),
    .exec_pl_wdata_i(x_wdata), .exec_done_i(done), .exec_rc_i(rc),
    .exec_out_len_i(olen), .dev_fatal_i(fatal), .dev_fw_halt_i(halt),
    .dev_media_i(media), .dev_mbox_rdy_i(mrdy), .dev_reset_need_i(rneed)
  );

  task automatic check(input string r, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [7:0] b, input logic [63:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; be = b; wdata = d;
    @(negedge clk); req = 0; we = 0; be = '0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [63:0] d);
    @(negedge clk); req = 1; we = 0; addr = a;
    @(negedge clk); req = 0;
    total++;
    if (!rvalid) begin bad++; $display("FAIL R1: rvalid actual=0 expected=1"); end
    d = rdata;
  endtask

  task automatic exec_finish(input logic [15:0] c, input logic [20:0] l);
    @(negedge clk); done = 1; rc = c; olen = l;
    @(negedge clk); done = 0;
  endtask

  task automatic ring();
    bus_wr(10'h000, 8'hF0, 64'h1 << 32);
  endtask

  task automatic t_reset();
    logic [63:0] d;
    check("R2 busy after reset", 64'(busy), 64'h0);
    check("R3 start after reset", 64'(start), 64'h0);
    bus_rd(10'h000, d);
    check("R1 caps at reset", d, 64'h8);
    bus_wr(10'h000, 8'h0F, 64'hFFFF_FFFF);
    bus_rd(10'h000, d);
    check("R1 caps read-only", d, 64'h8);
  endtask

  task automatic t_cmd();
    logic [63:0] d;
    bus_wr(10'h008, 8'hFF, 64'hFFFF_FFE0_0012_4000);
    bus_rd(10'h008, d);
    check("R4 command full write", d, 64'h0000_0000_0012_4000);
    bus_wr(10'h008, 8'h01, 64'hAB);
    bus_rd(10'h008, d);
    check("R4 command lane 0", d, 64'h0000_0000_0012_40AB);
    bus_wr(10'h008, 8'h10, 64'h0000_00FF_0000_0000);
    bus_rd(10'h008, d);
    check("R4 command lane 4", d, 64'h0000_001F_0012_40AB);
    bus_wr(10'h008, 8'hFF, 64'h0000_0000_0012_4000);
  endtask

  task automatic t_payload();
    logic [63:0] d;
    bus_wr(10'h020, 8'hFF, 64'h1111_2222_3333_4444);
    bus_wr(10'h118, 8'hFF, 64'hDEAD_BEEF_0BAD_F00D);
    bus_wr(10'h118, 8'h02, 64'h0000_0000_0000_5500);
    bus_rd(10'h020, d);
    check("R9 payload first word", d, 64'h1111_2222_3333_4444);
    bus_rd(10'h118, d);
    check("R9 payload last word lane write", d, 64'hDEAD_BEEF_0BAD_550D);
    bus_wr(10'h028, 8'hFF, 64'h0);
    @(negedge clk); x_addr = 5'd31; #1;
    check("R9 executor read", x_rdata, 64'hDEAD_BEEF_0BAD_550D);
  endtask

  task automatic t_ring();
    logic [63:0] d;
    bus_wr(10'h000, 8'hF0, 64'h0);
    check("R2 zero write leaves doorbell", 64'(busy), 64'h0);
    check("R3 no start on zero write", 64'(start), 64'h0);
    ring();
    check("R3 start pulse", 64'(start), 64'h1);
    check("R2 doorbell set", 64'(busy), 64'h1);
    check("R3 opcode out", 64'(opc), 64'h4000);
    check("R3 length out", 64'(len), 64'h12);
    @(negedge clk);
    check("R3 start one cycle", 64'(start), 64'h0);
    bus_rd(10'h000, d);
    check("R2 doorbell readback", d, 64'h0000_0001_0000_0008);
  endtask

  task automatic t_lock();
    logic [63:0] d;
    bus_wr(10'h008, 8'hFF, 64'h0000_0000_0033_7777);
    bus_rd(10'h008, d);
    check("R5 command locked", d, 64'h0000_0000_0012_4000);
    check("R5 opcode out locked", 64'(opc), 64'h4000);
    bus_wr(10'h020, 8'hFF, 64'h2222_2222_2222_2222);
    bus_rd(10'h020, d);
    check("R5 payload locked", d, 64'h1111_2222_3333_4444);
    @(negedge clk); x_we = 1; x_addr = 5'd1; x_wdata = 64'hCAFE_0000_1234_5678;
    @(negedge clk); x_we = 0;
    bus_rd(10'h028, d);
    check("R9 executor write while busy", d, 64'hCAFE_0000_1234_5678);
  endtask

  task automatic t_done();
    logic [63:0] d;
    exec_finish(16'h0005, 21'h40);
    check("R6 doorbell cleared", 64'(busy), 64'h0);
    bus_rd(10'h010, d);
    check("R6 return code", d, 64'h0000_0005_0000_0000);
    bus_rd(10'h008, d);
    check("R6 output length with opcode", d, 64'h0000_0000_0040_4000);
    bus_rd(10'h000, d);
    check("R6 doorbell readback clear", d, 64'h8);
  endtask

  task automatic t_idle();
    logic [63:0] d;
    exec_finish(16'h0077, 21'h99);
    check("R7 done while idle keeps doorbell", 64'(busy), 64'h0);
    bus_rd(10'h010, d);
    check("R7 status kept", d, 64'h0000_0005_0000_0000);
    bus_rd(10'h008, d);
    check("R7 command kept", d, 64'h0000_0000_0040_4000);
    @(negedge clk); x_we = 1; x_addr = 5'd1; x_wdata = 64'h0;
    @(negedge clk); x_we = 0;
    bus_rd(10'h028, d);
    check("R9 executor write while idle ignored", d, 64'hCAFE_0000_1234_5678);
    repeat (6) @(negedge clk);
    bus_rd(10'h010, d);
    check("R8 status stable", d, 64'h0000_0005_0000_0000);
    bus_rd(10'h020, d);
    check("R8 payload stable", d, 64'h1111_2222_3333_4444);
  endtask

  task automatic t_second();
    logic [63:0] d;
    bus_wr(10'h008, 8'hFF, 64'h0000_0000_0000_0001);
    ring();
    check("R3 second start", 64'(start), 64'h1);
    check("R3 second opcode", 64'(opc), 64'h0001);
    exec_finish(16'h0000, 21'h8);
    bus_rd(10'h010, d);
    check("R6 success code", d, 64'h0);
    bus_rd(10'h008, d);
    check("R6 second output length", d, 64'h0000_0000_0008_0001);
  endtask

  task automatic t_mdev();
    logic [63:0] d;
    fatal = 1; halt = 0; media = 2'd2; mrdy = 1; rneed = 3'd4;
    bus_rd(10'h200, d);
    check("R10 device status pattern a", d, 64'h99);
    fatal = 0; halt = 1; media = 2'd1; mrdy = 0; rneed = 3'd3;
    bus_rd(10'h200, d);
    check("R10 device status pattern b", d, 64'h66);
  endtask

  task automatic t_unmapped();
    logic [63:0] d;
    bus_rd(10'h018, d);
    check("R11 unmapped 0x18", d, 64'h0);
    bus_rd(10'h180, d);
    check("R11 unmapped 0x180", d, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cmd();
    t_payload();
    t_ring();
    t_lock();
    t_done();
    t_idle();
    t_second();
    t_mdev();
    t_unmapped();
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule